// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

The unit latches single-cycle event pulses from three groups of sources into status registers. It drives one level-sensitive request line per group toward a processor. Software reads the status words over a small register port. It acknowledges events by writing ones to the bits it has handled, and it picks which events may raise the main and DMA lines by loading mask bits.

There are three groups. The main group has a status register and a separate mask register. The DMA group keeps its 16 status bits and 16 mask bits together in one 32-bit word. A clearing write to that word touches only the status half. The mask half is loaded through its own address. The bus-flag group has no mask, and its line is raised whenever any flag is set. Each request line is a flop. Its value always matches the status and mask state that is visible in the same cycle, and it rises again as soon as a masked-in bit is set again.

Top module: `irqStatusUnit`

## Requirements
- R1: Reset (active-low `rstN`) clears all status, mask and flag bits, and all three request lines read 0.
- R2: A 1 on a source input during a clock edge sets the matching status bit. The bit then stays set until software clears it.
- R3: A write to address 0 (main status) or address 4 (bus flags) clears each bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When a source pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: A write to address 1 loads the main mask from the low data bits. `mainIrq` equals the OR over all bits of main status AND main mask, and it is valid in the cycle after the edge that changed either of them.
- R6: A read of address 2 returns the DMA mask in bits [31:16] and the DMA status in bits [15:0]. A write to address 2 clears the status bits selected by data bits [15:0] and leaves the mask half unchanged, whatever the upper data bits hold.
- R7: A write to address 3 loads the DMA mask from data bits [31:16] and leaves the DMA status unchanged. A read of address 3 returns the same word as address 2.
- R8: `dmaIrq` equals the OR over all bits of DMA status AND DMA mask, with the same timing as R5.
- R9: `busIrq` is 1 exactly when at least one bus flag is set. No mask applies to it.
- R10: Writes to addresses 5 to 7 change no register. Reads of those addresses return 0.
- R11: A request line that fell because its status was cleared rises again when a masked-in bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register word address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| mainSrc | input | 16 | Main event pulses |
| dmaSrc | input | 16 | DMA event pulses |
| busSrc | input | 16 | Bus-flag event pulses |
| mainIrq | output | 1 | Main request line |
| dmaIrq | output | 1 | DMA request line |
| busIrq | output | 1 | Bus-flag request line |

## Verification
The bench drives a write to the packed DMA word with the upper data half all ones. A design that applied the clear to the full word would wipe the mask and drop `dmaIrq` with no visible cause. It puts a source pulse and a clearing write on the same bit in one cycle. Letting the clear win there would silently lose an event. It writes to unused addresses and then reads back every register, which exposes a decoder that aliases onto a real register. It also clears a bit, sets it again, and checks that the request line rises a second time. A line that latched low, or one derived from stale state, would stay low.

// File: rtl/irqUnitPkg.sv
package irqUnitPkg;

  typedef enum logic [2:0] {
    SEL_MAIN_STAT = 3'd0,
    SEL_MAIN_MASK = 3'd1,
    SEL_DMA_WORD  = 3'd2,
    SEL_DMA_MASK  = 3'd3,
    SEL_BUS_FLAG  = 3'd4,
    SEL_NONE      = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrMainStat;
    logic    wrMainMask;
    logic    wrDmaStat;
    logic    wrDmaMask;
    logic    wrBusFlag;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irqW1cReg.sv
// Sticky status bank: sources set, write-one clears, set beats clear.
module irqW1cReg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] src,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q,
  output logic [W-1:0] qNext
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign qNext[b] = src[b] | (q[b] & ~clr[b]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= qNext;
  end

  // R2: bits stay put when nothing sets or clears them
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (src == '0 && clr == '0) |=> $stable(q));

  // R4: a pulsed bit is set after the edge even under a clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (src != '0) |=> ((q & $past(src)) == $past(src)));

  // R3: cleared bits with no pulse read zero afterwards
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((clr & ~src) != '0) |=> ((q & $past(clr & ~src)) == '0));

endmodule

// File: rtl/irqUnitCtrl.sv
module irqUnitCtrl
  import irqUnitPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobe_t       strb
);

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    case (busAddr)
      ADDR_W'(0): begin strb.rdSel = SEL_MAIN_STAT; strb.wrMainStat = busWrEn; end
      ADDR_W'(1): begin strb.rdSel = SEL_MAIN_MASK; strb.wrMainMask = busWrEn; end
      ADDR_W'(2): begin strb.rdSel = SEL_DMA_WORD;  strb.wrDmaStat  = busWrEn; end
      ADDR_W'(3): begin strb.rdSel = SEL_DMA_MASK;  strb.wrDmaMask  = busWrEn; end
      ADDR_W'(4): begin strb.rdSel = SEL_BUS_FLAG;  strb.wrBusFlag  = busWrEn; end
      default:    ;
    endcase
  end

  // R10: at most one register is written per cycle, none without a strobe
  p_one_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMainStat, strb.wrMainMask, strb.wrDmaStat,
              strb.wrDmaMask, strb.wrBusFlag}));
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> ({strb.wrMainStat, strb.wrMainMask, strb.wrDmaStat,
                   strb.wrDmaMask, strb.wrBusFlag} == '0));

endmodule

// File: rtl/irqUnitDatapath.sv
module irqUnitDatapath
  import irqUnitPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAIN_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [MAIN_W-1:0]   mainSrc,
  input  logic [DATA_W/2-1:0] dmaSrc,
  input  logic [BUS_W-1:0]    busSrc,
  output logic                mainIrq,
  output logic                dmaIrq,
  output logic                busIrq
);

  localparam int DMA_W = DATA_W / 2;

  logic [MAIN_W-1:0] mainStat, mainStatNext, mainMask, mainMaskNext;
  logic [DMA_W-1:0]  dmaStat, dmaStatNext, dmaMask, dmaMaskNext;
  logic [BUS_W-1:0]  busFlag, busFlagNext;

  irqW1cReg #(.W(MAIN_W)) i_mainStat (
    .clk(clk), .rstN(rstN), .src(mainSrc),
    .clr(strb.wrMainStat ? busWdata[MAIN_W-1:0] : '0),
    .q(mainStat), .qNext(mainStatNext));

  irqW1cReg #(.W(DMA_W)) i_dmaStat (
    .clk(clk), .rstN(rstN), .src(dmaSrc),
    .clr(strb.wrDmaStat ? busWdata[DMA_W-1:0] : '0),
    .q(dmaStat), .qNext(dmaStatNext));

  irqW1cReg #(.W(BUS_W)) i_busFlag (
    .clk(clk), .rstN(rstN), .src(busSrc),
    .clr(strb.wrBusFlag ? busWdata[BUS_W-1:0] : '0),
    .q(busFlag), .qNext(busFlagNext));

  assign mainMaskNext = strb.wrMainMask ? busWdata[MAIN_W-1:0] : mainMask;
  assign dmaMaskNext  = strb.wrDmaMask  ? busWdata[DATA_W-1:DMA_W] : dmaMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainMask <= '0;
      dmaMask  <= '0;
      mainIrq  <= 1'b0;
      dmaIrq   <= 1'b0;
      busIrq   <= 1'b0;
    end else begin
      mainMask <= mainMaskNext;
      dmaMask  <= dmaMaskNext;
      mainIrq  <= |(mainStatNext & mainMaskNext);
      dmaIrq   <= |(dmaStatNext & dmaMaskNext);
      busIrq   <= |busFlagNext;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_MAIN_STAT: busRdata = DATA_W'(mainStat);
      SEL_MAIN_MASK: busRdata = DATA_W'(mainMask);
      SEL_DMA_WORD,
      SEL_DMA_MASK:  busRdata = {dmaMask, dmaStat};
      SEL_BUS_FLAG:  busRdata = DATA_W'(busFlag);
      default:       busRdata = '0;
    endcase
  end

  // R5: main line tracks masked status held in the registers
  p_main_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    mainIrq == |(mainStat & mainMask));
  // R8: DMA line tracks its packed status and mask halves
  p_dma_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    dmaIrq == |(dmaStat & dmaMask));
  // R9: bus line follows any set flag
  p_bus_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    busIrq == (busFlag != '0));
  // R6: a status-clear write on the DMA word never moves the mask half
  p_dma_mask_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDmaStat && !strb.wrDmaMask) |=> $stable(dmaMask));
  // R7: a mask load never clears DMA status
  p_dma_stat_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDmaMask && !strb.wrDmaStat) |=> ((dmaStat & $past(dmaStat)) == $past(dmaStat)));

endmodule

// File: rtl/irqStatusUnit.sv
module irqStatusUnit
  import irqUnitPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int MAIN_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [MAIN_W-1:0]   mainSrc,
  input  logic [DATA_W/2-1:0] dmaSrc,
  input  logic [BUS_W-1:0]    busSrc,
  output logic                mainIrq,
  output logic                dmaIrq,
  output logic                busIrq
);

  ctrlStrobe_t strb;

  irqUnitCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .strb(strb));

  irqUnitDatapath #(.DATA_W(DATA_W), .MAIN_W(MAIN_W), .BUS_W(BUS_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .busRdata(busRdata),
    .mainSrc(mainSrc), .dmaSrc(dmaSrc), .busSrc(busSrc),
    .mainIrq(mainIrq), .dmaIrq(dmaIrq), .busIrq(busIrq));

endmodule

// File: tb/test_irqStatusUnit.sv
`timescale 1ns/1ps
module test_irqStatusUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] mainSrc = '0, dmaSrc = '0, busSrc = '0;
  logic        mainIrq, dmaIrq, busIrq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqStatusUnit i_irqStatusUnit (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .mainSrc(mainSrc),
    .dmaSrc(dmaSrc), .busSrc(busSrc), .mainIrq(mainIrq), .dmaIrq(dmaIrq),
    .busIrq(busIrq));

  typedef struct packed {
    logic        wr;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [15:0] ms;
    logic [15:0] ds;
    logic [15:0] bs;
    logic [2:0]  ra;
    logic [31:0] rd;
    logic [2:0]  irq;   // {main, dma, bus}
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 32'h0,        16'h0005, 16'h0,    16'h0,    3'd0, 32'h00000005, 3'b000, 8'd2},
    '{1'b1, 3'd1, 32'h00000004, 16'h0,    16'h0,    16'h0,    3'd1, 32'h00000004, 3'b100, 8'd5},
    '{1'b1, 3'd0, 32'h00000004, 16'h0,    16'h0,    16'h0,    3'd0, 32'h00000001, 3'b000, 8'd3},
    '{1'b1, 3'd0, 32'h00000005, 16'h0004, 16'h0,    16'h0,    3'd0, 32'h00000004, 3'b100, 8'd4},
    '{1'b1, 3'd0, 32'h00000004, 16'h0,    16'h0,    16'h0,    3'd0, 32'h00000000, 3'b000, 8'd3},
    '{1'b0, 3'd0, 32'h0,        16'h0,    16'h8001, 16'h0,    3'd2, 32'h00008001, 3'b000, 8'd2},
    '{1'b1, 3'd3, 32'h00010000, 16'h0,    16'h0,    16'h0,    3'd2, 32'h00018001, 3'b010, 8'd7},
    '{1'b1, 3'd2, 32'hFFFF0001, 16'h0,    16'h0,    16'h0,    3'd2, 32'h00018000, 3'b000, 8'd6},
    '{1'b1, 3'd3, 32'h80000000, 16'h0,    16'h0,    16'h0,    3'd3, 32'h80008000, 3'b010, 8'd8},
    '{1'b1, 3'd2, 32'h00008000, 16'h0,    16'h0,    16'h0,    3'd2, 32'h80000000, 3'b000, 8'd6},
    '{1'b0, 3'd0, 32'h0,        16'h0,    16'h0,    16'h0102, 3'd4, 32'h00000102, 3'b001, 8'd9},
    '{1'b1, 3'd4, 32'h00000002, 16'h0,    16'h0,    16'h0,    3'd4, 32'h00000100, 3'b001, 8'd3},
    '{1'b1, 3'd4, 32'h00000100, 16'h0,    16'h0,    16'h0,    3'd4, 32'h00000000, 3'b000, 8'd9},
    '{1'b1, 3'd7, 32'hFFFFFFFF, 16'h0002, 16'h0,    16'h0,    3'd0, 32'h00000002, 3'b000, 8'd10},
    '{1'b1, 3'd5, 32'hFFFFFFFF, 16'h0,    16'h0,    16'h0,    3'd1, 32'h00000004, 3'b000, 8'd10},
    '{1'b0, 3'd0, 32'h0,        16'h0,    16'h0,    16'h0,    3'd6, 32'h00000000, 3'b000, 8'd10},
    '{1'b0, 3'd0, 32'h0,        16'h0004, 16'h0,    16'h0,    3'd0, 32'h00000006, 3'b100, 8'd11}
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic readAt(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  logic [31:0] rv;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state at every mapped address and on the lines
    for (int a = 0; a < 5; a++) begin
      readAt(3'(a), rv);
      check(1, "reset register", rv, 32'h0);
    end
    check(1, "reset lines", {29'h0, mainIrq, dmaIrq, busIrq}, 32'h0);

    // Vector walk: one write/pulse cycle, then a read and line check
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busWrEn  = VECS[i].wr;
      busAddr  = VECS[i].wa;
      busWdata = VECS[i].wd;
      mainSrc  = VECS[i].ms;
      dmaSrc   = VECS[i].ds;
      busSrc   = VECS[i].bs;
      @(negedge clk);
      busWrEn = 1'b0; busWdata = '0;
      mainSrc = '0; dmaSrc = '0; busSrc = '0;
      busAddr = VECS[i].ra;
      #1;
      check(int'(VECS[i].req), $sformatf("vector %0d readback", i), busRdata, VECS[i].rd);
      check(int'(VECS[i].req), $sformatf("vector %0d lines", i),
            {29'h0, mainIrq, dmaIrq, busIrq}, {29'h0, VECS[i].irq});
    end

    // R2: status holds across idle cycles
    repeat (4) @(negedge clk);
    readAt(3'd0, rv);
    check(2, "main status held idle", rv, 32'h00000006);

    // R11: DMA line rises again after being cleared
    @(negedge clk);
    dmaSrc = 16'h8000;
    @(negedge clk);
    dmaSrc = '0;
    #1 check(11, "dma line re-raised", {31'h0, dmaIrq}, 32'h1);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    #1 check(1, "lines in reset", {29'h0, mainIrq, dmaIrq, busIrq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    readAt(3'd2, rv);
    check(1, "dma word after reset", rv, 32'h0);
    readAt(3'd1, rv);
    check(1, "main mask after reset", rv, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule